// File: doc/BRIEF.md
# Retrigger-Immune Three-Cycle Pulse Generator

This block turns a press of an asynchronous push button into an output pulse that is high for exactly three clock cycles. The raw button first passes through a chain of synchronizing flip-flops. A small press detector then turns a button that stays down into a request that lasts a single cycle. A four-state controller answers that request with the fixed-width pulse.

Once a pulse has started, it runs to completion. A new press that arrives while the pulse is high neither stretches it nor starts it again. The pulse output comes straight from a dedicated flip-flop that is part of the controller's state, so no combinational logic lies between a register and the pin, and the output is not delayed by an extra cycle.

An active-high synchronous reset puts the controller in its idle state and clears the press detector and the synchronizer chain. The number of synchronizer stages is a parameter.

Top module: `fixed_pulse_timer`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `pulse_out` is 0.
- R2: Every pulse on `pulse_out` is high for exactly 3 consecutive cycles, followed by at least one low cycle.
- R3: A button held high for any number of cycles produces exactly one pulse.
- R4: `pulse_out` first reads high after the rising edge that comes SYNC_STAGES+1 edges after the edge that first samples `btn_async` high. With the default of 2 stages, it is the 4th edge, counting the sampling edge as the first.
- R5: A second press whose request reaches the controller while a pulse is high is ignored. The pulse still ends after 3 cycles and no further pulse follows. This applies to second presses sampled two or three edges after the first.
- R6: After the button has been released, a fresh press made after the pulse has ended produces a new full 3-cycle pulse.
- R7: Raising reset while a pulse is high forces `pulse_out` to 0 after the next rising edge, and the rest of the pulse is not emitted.
- R8: Controller state codes are idle=00, first=01, second=10, third=11. The controller leaves idle only on a request, and otherwise steps one code per cycle back to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| btn_async | input | 1 | Raw button level, asynchronous to clk |
| pulse_out | output | 1 | Registered three-cycle pulse |

## Verification
The hardest case to reach is a second request that lands while the pulse is still high. The request can only arrive after the synchronizer delay and one pass through the press detector, and the button must be released in between so that the detector returns to idle. The stimulus releases the button for one cycle and presses it again two or three edges after the first sampling edge. The requests then reach the controller in its second and third pulse states. A longer watch window afterwards confirms that neither request started a late pulse.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_FIRST  = 2'b01,
    ST_SECOND = 2'b10,
    ST_THIRD  = 2'b11
  } pulse_st_t;

  typedef enum logic [1:0] {
    PR_IDLE = 2'b00,
    PR_FIRE = 2'b01,
    PR_WAIT = 2'b10
  } press_st_t;
endpackage

// File: rtl/fpt_sync.sv
module fpt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_async;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fpt_press.sv
module fpt_press
  import fpt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic req
);
  press_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      PR_IDLE: if (level) st_d = PR_FIRE;
      PR_FIRE: st_d = level ? PR_WAIT : PR_IDLE;
      PR_WAIT: if (!level) st_d = PR_IDLE;
      default: st_d = PR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= PR_IDLE;
    else     st_q <= st_d;
  end

  assign req = (st_q == PR_FIRE);

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    req |=> !req); // R3
  AST_HELD_SILENT: assert property (@(posedge clk) disable iff (rst)
    (st_q == PR_WAIT && level) |=> !req); // R3
endmodule

// File: rtl/fpt_ctrl.sv
module fpt_ctrl
  import fpt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic pulse
);
  pulse_st_t st_q, st_d;
  logic      out_q, out_d;

  always_comb begin
    case (st_q)
      ST_IDLE:   st_d = req ? ST_FIRST : ST_IDLE;
      ST_FIRST:  st_d = ST_SECOND;
      ST_SECOND: st_d = ST_THIRD;
      default:   st_d = ST_IDLE;
    endcase
    out_d = (st_d != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      out_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      out_q <= out_d;
    end
  end

  assign pulse = out_q;

  AST_OUT_TRACKS_STATE: assert property (@(posedge clk) disable iff (rst)
    out_q == (st_q != ST_IDLE)); // R2
  AST_START_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && req) |=> st_q == ST_FIRST); // R8
  AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !req) |=> st_q == ST_IDLE); // R8
  AST_FIRST_STEP: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FIRST) |=> st_q == ST_SECOND); // R5
  AST_SECOND_STEP: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SECOND) |=> st_q == ST_THIRD); // R5
  AST_THIRD_ENDS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_THIRD) |=> (st_q == ST_IDLE && !out_q)); // R2
endmodule

// File: rtl/fixed_pulse_timer.sv
module fixed_pulse_timer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_async,
  output logic pulse_out
);
  logic btn_sync;
  logic press_req;

  fpt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (btn_async),
    .q_sync  (btn_sync)
  );

  fpt_press u_press (
    .clk   (clk),
    .rst   (rst),
    .level (btn_sync),
    .req   (press_req)
  );

  fpt_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .req   (press_req),
    .pulse (pulse_out)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !pulse_out); // R7
endmodule

// File: tb/fixed_pulse_timer_bench.sv
module fixed_pulse_timer_bench;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic pulse_out;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  fixed_pulse_timer #(.SYNC_STAGES(SYNC)) u_fixed_pulse_timer (
    .clk       (clk),
    .rst       (rst),
    .btn_async (btn),
    .pulse_out (pulse_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive btn at each negedge; sample pulse_out on the following negedges.
  task automatic watch(input int hold, input int gap2, input int hold2,
                       input int window, output int first, output int total,
                       output int runs);
    logic prev;
    first = -1; total = 0; runs = 0; prev = 1'b0;
    @(negedge clk);
    btn = (hold > 0);
    for (int i = 1; i <= window; i++) begin
      @(negedge clk);
      if (pulse_out) begin
        total++;
        if (first < 0) first = i;
        if (!prev) runs++;
      end
      prev = pulse_out;
      btn = (i < hold) || (gap2 > 0 && i >= gap2 && i < gap2 + hold2);
    end
    btn = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; btn = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 out during reset", pulse_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out after reset", pulse_out, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_short();
    int f, t, r;
    watch(1, 0, 0, 16, f, t, r);
    check("R4 short press latency", f, LAT);
    check("R2 short press width", t, 3);
    check("R2 short press runs", r, 1);
  endtask

  task automatic t_long(input int len);
    int f, t, r;
    watch(len, 0, 0, len + 16, f, t, r);
    check("R4 long press latency", f, LAT);
    check("R3 long press width", t, 3);
    check("R3 long press single pulse", r, 1);
  endtask

  task automatic t_retrigger(input int gap);
    int f, t, r;
    watch(1, gap, 1, 24, f, t, r);
    check("R5 retrigger start", f, LAT);
    check("R5 retrigger width", t, 3);
    check("R5 retrigger no extra pulse", r, 1);
  endtask

  task automatic t_fresh();
    int f, t, r;
    watch(1, 0, 0, 8, f, t, r);
    check("R6 first pulse width", t, 3);
    watch(1, 0, 0, 10, f, t, r);
    check("R6 fresh press latency", f, LAT);
    check("R6 fresh press width", t, 3);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    btn = 1'b1;
    @(negedge clk);
    btn = 1'b0;
    while (!pulse_out) @(negedge clk);
    check("R7 pulse started", pulse_out, 1);
    rst = 1'b1;
    @(negedge clk);
    check("R7 cut by reset", pulse_out, 0);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pulse_out) check("R7 no resumed pulse", 1, 0);
    end
    check("R7 quiet after reset", pulse_out, 0);
  endtask

  initial begin
    t_reset();
    t_short();
    t_long(2);
    t_long(9);
    t_retrigger(2);
    t_retrigger(3);
    t_fresh();
    t_reset_mid();
    t_short();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule